// File: doc/BRIEF.md
# Self-Refresh Entry and Clock Shutdown Sequencer

This block sits on the controller side of a registered DDR memory module and walks the module into and out of a fully powered-down retention state. On a sleep request from the idle operational state it issues the self-refresh entry command. It waits out the extra register stage that delays every command by a clock, then pulls the register reset low. It keeps clocks and command levels valid through the register deactivation window, and finally gates the module clocks and releases the command and address lines to high impedance. CKE stays driven low the whole time.

A wake request, accepted only in the powered-down state, runs the reverse path. The clocks come back and known deselect levels are driven with CKE low for a stabilization interval. Register reset is then released and an activation interval is waited out. After that CKE is raised, deselect is held for a parameterized exit interval, and the block reports ready. Each completed direction produces a one-cycle done pulse, and the current step is visible on a state output.

Top module: `srf_power_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after it, the block is powered down: state_o = 4, reg_reset_n = 0, clk_en = 0, cmd_oe = 0, addr_oe = 0, mem_cke = 0, cke_oe = 1, ready = 0, no done pulse.
- R2: A sleep_req sampled while ready is high puts the entry command (mem_cke 0, mem_cs_n 0, mem_ras_n 0, mem_cas_n 0, mem_we_n 1) on the pins for exactly one cycle, starting the next cycle, with state_o = 1 and reg_reset_n still high.
- R3: After the command, for REG_LATENCY cycles (state_o = 2) the pins carry deselect (all four command lines high) with mem_cke low and reg_reset_n still high.
- R4: reg_reset_n then goes low for T_INACT_CYC cycles (state_o = 3) while clk_en, cmd_oe and addr_oe all stay high, with deselect levels and mem_cke low.
- R5: Then the block parks (state_o = 4): clk_en = 0, cmd_oe = 0, addr_oe = 0, reg_reset_n = 0, mem_cke = 0 with cke_oe = 1, and enter_done is high for the first cycle only.
- R6: A wake_req sampled in the parked state starts T_STAB_CYC cycles (state_o = 5) with clk_en = 1, all output enables high, deselect, mem_cke low and reg_reset_n low.
- R7: Then reg_reset_n goes high for T_ACT_CYC cycles (state_o = 6) with mem_cke still low and deselect driven.
- R8: Then mem_cke goes high with deselect for T_EXIT_CYC cycles (state_o = 7). After that the block is operational (state_o = 0, ready = 1, mem_cke = 1, deselect, everything enabled), and exit_done is high for its first cycle only.
- R9: sleep_req has no effect in any state other than the operational one.
- R10: wake_req has no effect in any state other than the parked one.
- R11: mem_cke is never high while reg_reset_n or clk_en is low.
- R12: state_o encodes operational 0, command 1, pipeline wait 2, reset wait 3, parked 4, clock stabilization 5, activation 6, exit wait 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Request to enter self-refresh retention |
| wake_req | input | 1 | Request to return to operation |
| mem_cke | output | 1 | Clock enable to the module |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| cmd_oe | output | 4 | Per-pin drive enables: [3] cs, [2] ras, [1] cas, [0] we |
| addr_oe | output | 1 | Drive enable for the address bus |
| cke_oe | output | 1 | Drive enable for CKE, always high |
| reg_reset_n | output | 1 | Reset to the module's input register, active low |
| clk_en | output | 1 | Gate enable for the module clock outputs |
| state_o | output | 3 | Current sequencer step (R12 encoding) |
| ready | output | 1 | High while operational |
| enter_done | output | 1 | One-cycle pulse when the parked state is reached |
| exit_done | output | 1 | One-cycle pulse when operation resumes |

## Verification
The assertions assume the request inputs are synchronous to clk and change only between edges, and that every wait parameter is at least one cycle. The bench drives sleep_req and wake_req only on falling edges. It keeps all parameters small and non-zero, and it deliberately presents each request in states where it must be ignored, including held-high requests across whole sequences, so the properties see both accepted and rejected requests.

// File: rtl/srf_seq_pkg.sv
// Shared types for the self-refresh sequencer.
// Assumes: a 3-bit state code that is also driven out on state_o.
package srf_seq_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE    = 3'd0,
        ST_SRE_CMD   = 3'd1,
        ST_SRE_PIPE  = 3'd2,
        ST_RST_LOW   = 3'd3,
        ST_SLEEP     = 3'd4,
        ST_WAKE_CLK  = 3'd5,
        ST_WAKE_ACT  = 3'd6,
        ST_EXIT_WAIT = 3'd7
    } srf_state_e;

    // Pin levels produced for one state.
    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic reg_rst_n;
        logic clk_en;
        logic bus_oe;
    } srf_pins_t;

    localparam int CMD_PINS = 4;

endpackage

// File: rtl/srf_wait_timer.sv
// Down-counting interval timer.
// Loading value N-1 makes expired rise after N cycles in the loaded state.
// Assumes: load and load_val come from the controlling state machine.
module srf_wait_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Load on a state change, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Interval over when the count has reached zero.
    assign expired = (cnt == '0);

endmodule

// File: rtl/srf_seq_fsm.sv
// Step controller for self-refresh entry and exit.
// Accepts sleep only when operational, wake only when parked; every other
// step lasts a parameterized number of cycles timed by an external timer.
// Assumes: all wait parameters are at least 1.
module srf_seq_fsm
    import srf_seq_pkg::*;
#(
    parameter int REG_LATENCY = 1,
    parameter int T_INACT_CYC = 16,
    parameter int T_STAB_CYC  = 24,
    parameter int T_ACT_CYC   = 12,
    parameter int T_EXIT_CYC  = 10,
    parameter int CNT_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic             expired,
    output srf_state_e       state,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             enter_done,
    output logic             exit_done
);

    srf_state_e st, st_nxt;

    // Timer preset for a step: its length in cycles minus one.
    function automatic logic [CNT_W-1:0] wait_len(input srf_state_e s);
        case (s)
            ST_SRE_PIPE:  wait_len = CNT_W'(REG_LATENCY - 1);
            ST_RST_LOW:   wait_len = CNT_W'(T_INACT_CYC - 1);
            ST_WAKE_CLK:  wait_len = CNT_W'(T_STAB_CYC - 1);
            ST_WAKE_ACT:  wait_len = CNT_W'(T_ACT_CYC - 1);
            ST_EXIT_WAIT: wait_len = CNT_W'(T_EXIT_CYC - 1);
            default:      wait_len = '0;
        endcase
    endfunction

    // Next step: requests in the two resting states, timer elsewhere.
    always_comb begin
        st_nxt = st;
        case (st)
            ST_ACTIVE:    if (sleep_req) st_nxt = ST_SRE_CMD;
            ST_SRE_CMD:   if (expired)   st_nxt = ST_SRE_PIPE;
            ST_SRE_PIPE:  if (expired)   st_nxt = ST_RST_LOW;
            ST_RST_LOW:   if (expired)   st_nxt = ST_SLEEP;
            ST_SLEEP:     if (wake_req)  st_nxt = ST_WAKE_CLK;
            ST_WAKE_CLK:  if (expired)   st_nxt = ST_WAKE_ACT;
            ST_WAKE_ACT:  if (expired)   st_nxt = ST_EXIT_WAIT;
            ST_EXIT_WAIT: if (expired)   st_nxt = ST_ACTIVE;
            default:                     st_nxt = ST_SLEEP;
        endcase
    end

    // Timer is reloaded on every step change.
    assign load     = (st_nxt != st);
    assign load_val = wait_len(st_nxt);

    // State register; reset parks the module.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_SLEEP;
        end else begin
            st <= st_nxt;
        end
    end

    // Completion pulses, aligned with the first cycle of the resting state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enter_done <= 1'b0;
            exit_done  <= 1'b0;
        end else begin
            enter_done <= (st == ST_RST_LOW)   && (st_nxt == ST_SLEEP);
            exit_done  <= (st == ST_EXIT_WAIT) && (st_nxt == ST_ACTIVE);
        end
    end

    assign state = st;

endmodule

// File: rtl/srf_pin_decode.sv
// Maps the current step onto module pin levels and drive enables.
// Assumes: the state input is registered, so the outputs change once per edge.
module srf_pin_decode
    import srf_seq_pkg::*;
(
    input  srf_state_e state,
    output srf_pins_t  pins
);

    // Deselect with everything powered is the base; each step alters it.
    always_comb begin
        pins.cke       = 1'b0;
        pins.cs_n      = 1'b1;
        pins.ras_n     = 1'b1;
        pins.cas_n     = 1'b1;
        pins.we_n      = 1'b1;
        pins.reg_rst_n = 1'b1;
        pins.clk_en    = 1'b1;
        pins.bus_oe    = 1'b1;
        case (state)
            ST_ACTIVE:    pins.cke = 1'b1;
            ST_SRE_CMD: begin
                pins.cs_n  = 1'b0;
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
            end
            ST_SRE_PIPE:  pins.cke = 1'b0;
            ST_RST_LOW:   pins.reg_rst_n = 1'b0;
            ST_SLEEP: begin
                pins.reg_rst_n = 1'b0;
                pins.clk_en    = 1'b0;
                pins.bus_oe    = 1'b0;
            end
            ST_WAKE_CLK:  pins.reg_rst_n = 1'b0;
            ST_WAKE_ACT:  pins.reg_rst_n = 1'b1;
            ST_EXIT_WAIT: pins.cke = 1'b1;
            default: begin
                pins.reg_rst_n = 1'b0;
                pins.clk_en    = 1'b0;
                pins.bus_oe    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/srf_power_seq.sv
// Self-refresh entry / clock shutdown sequencer for a registered DDR module.
// Issues the entry command, waits out the register stage, resets the register,
// holds valid levels for the deactivation window, then gates clocks and
// releases the command and address bus; wake reverses the path.
// Assumes: requests synchronous to clk; all wait parameters at least 1.
module srf_power_seq
    import srf_seq_pkg::*;
#(
    parameter int REG_LATENCY = 1,
    parameter int T_INACT_CYC = 16,
    parameter int T_STAB_CYC  = 24,
    parameter int T_ACT_CYC   = 12,
    parameter int T_EXIT_CYC  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                wake_req,
    output logic                mem_cke,
    output logic                mem_cs_n,
    output logic                mem_ras_n,
    output logic                mem_cas_n,
    output logic                mem_we_n,
    output logic [CMD_PINS-1:0] cmd_oe,
    output logic                addr_oe,
    output logic                cke_oe,
    output logic                reg_reset_n,
    output logic                clk_en,
    output logic [2:0]          state_o,
    output logic                ready,
    output logic                enter_done,
    output logic                exit_done
);

    localparam int MAX_A    = (REG_LATENCY > T_INACT_CYC) ? REG_LATENCY : T_INACT_CYC;
    localparam int MAX_B    = (T_STAB_CYC > T_ACT_CYC) ? T_STAB_CYC : T_ACT_CYC;
    localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_WAIT = (MAX_C > T_EXIT_CYC) ? MAX_C : T_EXIT_CYC;
    localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);

    srf_state_e       state;
    srf_pins_t        pins;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;

    srf_seq_fsm #(
        .REG_LATENCY (REG_LATENCY),
        .T_INACT_CYC (T_INACT_CYC),
        .T_STAB_CYC  (T_STAB_CYC),
        .T_ACT_CYC   (T_ACT_CYC),
        .T_EXIT_CYC  (T_EXIT_CYC),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wake_req   (wake_req),
        .expired    (expired),
        .state      (state),
        .load       (load),
        .load_val   (load_val),
        .enter_done (enter_done),
        .exit_done  (exit_done)
    );

    srf_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    srf_pin_decode u_dec (
        .state (state),
        .pins  (pins)
    );

    // Each command pin gets its own enable, all released together.
    for (genvar i = 0; i < CMD_PINS; i++) begin : g_cmd_oe
        assign cmd_oe[i] = pins.bus_oe;
    end

    assign mem_cke     = pins.cke;
    assign mem_cs_n    = pins.cs_n;
    assign mem_ras_n   = pins.ras_n;
    assign mem_cas_n   = pins.cas_n;
    assign mem_we_n    = pins.we_n;
    assign addr_oe     = pins.bus_oe;
    assign cke_oe      = 1'b1;
    assign reg_reset_n = pins.reg_rst_n;
    assign clk_en      = pins.clk_en;
    assign state_o     = state;
    assign ready       = (state == ST_ACTIVE);

endmodule

// File: rtl/srf_seq_chk.sv
// Property checker for the self-refresh sequencer, attached by bind.
// Assumes: requests change only between clock edges.
module srf_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       wake_req,
    input logic       mem_cke,
    input logic       mem_cs_n,
    input logic       mem_ras_n,
    input logic       mem_cas_n,
    input logic       mem_we_n,
    input logic [3:0] cmd_oe,
    input logic       addr_oe,
    input logic       cke_oe,
    input logic       reg_reset_n,
    input logic       clk_en,
    input logic       ready,
    input logic       enter_done,
    input logic       exit_done
);

    logic sre_cmd;
    assign sre_cmd = !mem_cke && !mem_cs_n && !mem_ras_n && !mem_cas_n && mem_we_n;

    a_r11_cke_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cke |-> (reg_reset_n && clk_en));

    a_r5_parked_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (cmd_oe == 4'b0000 && !addr_oe && cke_oe && !mem_cke && !reg_reset_n));

    a_r2_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        sre_cmd |=> (mem_cs_n && !mem_cke && reg_reset_n));

    a_r9_sleep_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && sleep_req) |=> sre_cmd);

    a_r3_gap_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_reset_n) |-> ($past(mem_cs_n) && !mem_cke && clk_en));

    a_r4_gate_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> (!reg_reset_n && $past(!reg_reset_n)));

    a_r6_clock_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> (!mem_cke && !reg_reset_n));

    a_r5_enter_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        enter_done |=> !enter_done);

    a_r8_exit_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        exit_done |-> (ready && !$past(ready)));

    a_r10_wake_parked_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wake_req) |=> ready || sre_cmd);

endmodule

bind srf_power_seq srf_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .wake_req    (wake_req),
    .mem_cke     (mem_cke),
    .mem_cs_n    (mem_cs_n),
    .mem_ras_n   (mem_ras_n),
    .mem_cas_n   (mem_cas_n),
    .mem_we_n    (mem_we_n),
    .cmd_oe      (cmd_oe),
    .addr_oe     (addr_oe),
    .cke_oe      (cke_oe),
    .reg_reset_n (reg_reset_n),
    .clk_en      (clk_en),
    .ready       (ready),
    .enter_done  (enter_done),
    .exit_done   (exit_done)
);

// File: tb/tb_srf_power_seq.sv
// Bench: behavioural step model compared with every output on every cycle.
module tb_srf_power_seq;

    localparam int P_LAT   = 2;
    localparam int P_INACT = 5;
    localparam int P_STAB  = 7;
    localparam int P_ACT   = 4;
    localparam int P_EXIT  = 6;
    localparam int WD_LIMIT = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [3:0] cmd_oe;
    logic       addr_oe, cke_oe, reg_reset_n, clk_en, ready, enter_done, exit_done;
    logic [2:0] state_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ms = 4;
    int mc = 0;
    bit m_ed = 1'b0;
    bit m_xd = 1'b0;
    int ed_seen = 0;
    int xd_seen = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    srf_power_seq #(
        .REG_LATENCY (P_LAT),
        .T_INACT_CYC (P_INACT),
        .T_STAB_CYC  (P_STAB),
        .T_ACT_CYC   (P_ACT),
        .T_EXIT_CYC  (P_EXIT)
    ) dut (
        .clk (clk), .rst_n (rst_n), .sleep_req (sleep_req), .wake_req (wake_req),
        .mem_cke (mem_cke), .mem_cs_n (mem_cs_n), .mem_ras_n (mem_ras_n),
        .mem_cas_n (mem_cas_n), .mem_we_n (mem_we_n), .cmd_oe (cmd_oe),
        .addr_oe (addr_oe), .cke_oe (cke_oe), .reg_reset_n (reg_reset_n),
        .clk_en (clk_en), .state_o (state_o), .ready (ready),
        .enter_done (enter_done), .exit_done (exit_done)
    );

    function automatic int dur(input int s);
        case (s)
            1: return 1;
            2: return P_LAT;
            3: return P_INACT;
            5: return P_STAB;
            6: return P_ACT;
            7: return P_EXIT;
            default: return 1;
        endcase
    endfunction

    // Expected pins {state,cke,cs,ras,cas,we,rstn,clk_en,cmd_oe,addr_oe,cke_oe,ready,ed,xd}
    function automatic logic [18:0] expect_pins(input int s, input bit ed, input bit xd);
        logic cke, cs, ras, cas, rstn, ce, oe;
        cke = (s == 0 || s == 7);
        cs = (s != 1); ras = (s != 1); cas = (s != 1);
        rstn = !(s == 3 || s == 4 || s == 5);
        ce = (s != 4); oe = (s != 4);
        return {3'(s), cke, cs, ras, cas, 1'b1, rstn, ce, {4{oe}}, oe, 1'b1, (s == 0), ed, xd};
    endfunction

    function automatic string req_of(input int s);
        case (s)
            0: return "R8/R12";
            1: return "R2/R12";
            2: return "R3/R12";
            3: return "R4/R12";
            4: return "R5/R12";
            5: return "R6/R12";
            6: return "R7/R12";
            default: return "R8/R12";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: advances on each rising edge from the sampled requests.
    always @(posedge clk) begin
        cyc++;
        m_ed = 1'b0;
        m_xd = 1'b0;
        if (!rst_n) begin
            ms = 4; mc = 0;
        end else if (ms == 0) begin
            if (sleep_req) begin ms = 1; mc = 0; end
        end else if (ms == 4) begin
            if (wake_req) begin ms = 5; mc = 0; end
        end else begin
            mc++;
            if (mc == dur(ms)) begin
                mc = 0;
                if (ms == 3) begin ms = 4; m_ed = 1'b1; end
                else if (ms == 7) begin ms = 0; m_xd = 1'b1; end
                else ms = ms + 1;
            end
        end
    end

    // Per-cycle comparison away from the rising edge.
    always @(negedge clk) begin
        logic [18:0] act, exp;
        act = {state_o, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, reg_reset_n,
               clk_en, cmd_oe, addr_oe, cke_oe, ready, enter_done, exit_done};
        exp = expect_pins(ms, m_ed, m_xd);
        check(act === exp, req_of(ms), int'(act), int'(exp));
        // R11 safety invariant
        check(!(mem_cke && (!reg_reset_n || !clk_en)), "R11", int'(mem_cke), 0);
        if (enter_done) ed_seen++;
        if (exit_done) xd_seen++;
    end

    // Watchdog: an expired run is a failed check.
    always @(posedge clk) begin
        if (cyc >= WD_LIMIT && !done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_state(input int s);
        for (int n = 0; n < 2000 && int'(state_o) != s; n++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values; R12 parked code is 4
        check(state_o == 3'd4, "R1 R12 state", int'(state_o), 4);
        check(!reg_reset_n && !clk_en && cmd_oe == 4'd0 && !addr_oe && !mem_cke && cke_oe
              && !ready && !enter_done && !exit_done, "R1 pins",
              int'({reg_reset_n, clk_en, cmd_oe, addr_oe, mem_cke, cke_oe, ready}), 2);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(state_o == 3'd4, "R1 stays parked", int'(state_o), 4);

        // First wake, single-cycle pulse
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        check(state_o == 3'd5, "R6 wake accepted", int'(state_o), 5);
        @(negedge clk);
        // R9: sleep during stabilization ignored
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        check(state_o != 3'd1 && !ready, "R9 sleep ignored while waking", int'(state_o), 5);
        wait_state(0);
        check(ready && mem_cke, "R8 operational", int'({ready, mem_cke}), 3);

        // R10: wake while operational ignored
        repeat (2) @(negedge clk);
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        check(state_o == 3'd0 && ready, "R10 wake ignored when ready", int'(state_o), 0);

        // Entry with a wake pulse during the reset wait
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        check(state_o == 3'd1 && !mem_cs_n && !mem_ras_n && !mem_cas_n && mem_we_n && !mem_cke,
              "R2 entry command", int'(state_o), 1);
        wait_state(3);
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        check(state_o == 3'd3, "R10 wake ignored in reset wait", int'(state_o), 3);
        wait_state(4);
        check(enter_done && cmd_oe == 4'd0 && !clk_en, "R5 parked with pulse",
              int'({enter_done, clk_en}), 2);

        // R9: held sleep in parked state ignored
        sleep_req = 1'b1; repeat (10) @(negedge clk);
        check(state_o == 3'd4 && !clk_en, "R9 sleep ignored when parked", int'(state_o), 4);
        sleep_req = 1'b0;

        // Held wake through the whole exit, then held sleep re-entry
        wake_req = 1'b1;
        wait_state(0);
        wake_req = 1'b0;
        sleep_req = 1'b1;
        @(negedge clk);
        check(state_o == 3'd1, "R2 re-entry from held sleep", int'(state_o), 1);
        wait_state(4);
        repeat (3) @(negedge clk);
        sleep_req = 1'b0;
        check(state_o == 3'd4, "R9 held sleep ignored after entry", int'(state_o), 4);

        // Done pulse counts
        check(ed_seen == 2, "R5 enter pulses", ed_seen, 2);
        check(xd_seen == 2, "R8 exit pulses", xd_seen, 2);

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule